// File: doc/BRIEF.md
# Flag-Driven Read Level Sequencer

This block sequences the reading of a flash page whose cells may have been reprogrammed in place one or more times. Every read begins with a sense at the lowest reference level (index 0). That sense also returns the page's overwrite flag field. When the field shows that the page has never been overwritten, the read finishes after that one sense.

When the field does show overwrites, the block decodes how many there were and issues a second sense at the matching raised reference level. Only then does it announce that the page data is ready. Cells below the selected level read as "1", so choosing the level from the flags makes the second sense return the newest data. A flag field that cannot be decoded, or a count above the configured overwrite limit, ends the read with an error pulse and no second sense.

Each sense command is held until the sense engine acknowledges it. Two tallies count completed reads that needed one sense and completed reads that needed two. Throughput checks use these tallies.

Top module: `flag_read_seq`

## Requirements
- R1: After reset `busy`, `sense_go`, `data_rdy` and `rd_err` are 0, and both tallies `n_one` and `n_two` are 0.
- R2: A request (`rd_req` high while idle) causes `sense_go` to be high on the next cycle, with `sense_lvl` = 0 and `sense_page` equal to the requested page.
- R3: If the flags returned with the first `sense_ack` are all ones, `data_rdy` is high in the cycle after that acknowledge. `sense_go` is low in that cycle and no second sense is issued.
- R4: The overwrite count is the number of zero bits in the flag field. Valid fields fill with zeros from bit 0 upward, for example 1110 = 1, 1100 = 2 and 1000 = 3. For a valid nonzero count k that is no larger than MAX_OW, the cycle after the first acknowledge shows `sense_go` high with `sense_lvl` = k and the same page. `data_rdy` follows in the cycle after the second acknowledge.
- R5: A flag field that is not of the form described in R4 (for example 1010 or 0111) gives a one-cycle `rd_err` in the cycle after the first acknowledge. In that case there is no second sense and no `data_rdy`.
- R6: A count above MAX_OW (default 3, so 0000 with count 4) is handled the same way as in R5.
- R7: While `sense_go` is high and `sense_ack` is low, `sense_go`, `sense_lvl` and `sense_page` stay unchanged into the next cycle.
- R8: `n_one` increments once for each read that completes after one sense. `n_two` increments once for each read that completes after two senses. Reads that end with an error change neither tally.
- R9: `rd_req` is ignored while `busy` is high. The page of the command in progress does not change.
- R10: `data_rdy` and `rd_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, taken when idle |
| rd_page | input | PAGE_W | Page address of the request |
| busy | output | 1 | A read is in progress |
| sense_go | output | 1 | Sense command valid, held until acknowledged |
| sense_lvl | output | LVL_W | Reference level index of the command |
| sense_page | output | PAGE_W | Page address of the command |
| sense_ack | input | 1 | Sense complete, one cycle |
| sense_flags | input | FLAG_W | Overwrite flags, valid with `sense_ack` |
| data_rdy | output | 1 | Page data ready, one cycle |
| rd_err | output | 1 | Read aborted on bad flags, one cycle |
| n_one | output | CNT_W | Completed single-sense reads |
| n_two | output | CNT_W | Completed two-sense reads |

## Verification
A wrong sequencer state shows up one cycle after a sense acknowledge. It appears as a wrong `sense_lvl` on the follow-up command, as a second command where none belongs, or as a missing or misplaced `data_rdy` or `rd_err` pulse. A wrong flag decode shows up directly as a wrong raised level or as a wrong choice between error and completion. A wrong tally shows up as a difference in `n_one` or `n_two` right after the read that should have moved it.

// File: rtl/rls_pkg.sv
package rls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_BASE   = 2'd1,
      ST_RAISED = 2'd2
   } rls_state_e;

   function automatic int count_bits(input int span);
      return $clog2(span + 1);
   endfunction
endpackage

// File: rtl/rls_flag_decode.sv
module rls_flag_decode #(
   parameter int FLAG_W = 4,
   parameter int MAX_OW = 3,
   parameter int STRICT = 1,
   localparam int CW    = rls_pkg::count_bits(FLAG_W)
) (
   input  logic [FLAG_W-1:0] flags,
   output logic [CW-1:0]     zeros,
   output logic              pristine,
   output logic              bad
);
   localparam logic [FLAG_W-1:0] ALL1 = {FLAG_W{1'b1}};

   logic shape_ok;

   always_comb begin
      zeros = '0;
      for (int i = 0; i < FLAG_W; i++) begin
         if (!flags[i]) zeros = zeros + CW'(1);
      end
   end

   generate
      if (STRICT != 0) begin : g_strict
         always_comb shape_ok = (flags == (ALL1 << zeros));
      end else begin : g_loose
         always_comb shape_ok = 1'b1;
      end
   endgenerate

   assign pristine = (flags == ALL1);
   assign bad      = !shape_ok || (int'(zeros) > MAX_OW);

   // r4: a field of all ones is never treated as bad
   always_comb a_r4_pristine_ok : assert (!(pristine && bad));
endmodule

// File: rtl/rls_tally.sv
module rls_tally #(
   parameter int W   = 8,
   parameter int SAT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] nxt;

   generate
      if (SAT != 0) begin : g_sat
         always_comb nxt = (count == TOP) ? count : count + W'(1);
      end else begin : g_wrap
         always_comb nxt = count + W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= nxt;
   end

   a_r8_step : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && count != TOP) |=> count == $past(count) + W'(1));
   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/flag_read_seq.sv
module flag_read_seq #(
   parameter int PAGE_W = 16,
   parameter int FLAG_W = 4,
   parameter int MAX_OW = 3,
   parameter int LVL_W  = 3,
   parameter int CNT_W  = 8,
   parameter int STRICT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [PAGE_W-1:0] rd_page,
   output logic              busy,
   output logic              sense_go,
   output logic [LVL_W-1:0]  sense_lvl,
   output logic [PAGE_W-1:0] sense_page,
   input  logic              sense_ack,
   input  logic [FLAG_W-1:0] sense_flags,
   output logic              data_rdy,
   output logic              rd_err,
   output logic [CNT_W-1:0]  n_one,
   output logic [CNT_W-1:0]  n_two
);
   import rls_pkg::*;

   localparam int CW = count_bits(FLAG_W);

   generate
      if (FLAG_W < 1 || PAGE_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("flag_read_seq: widths must be positive");
      end
      if (MAX_OW < 1 || MAX_OW > FLAG_W) begin : g_bad_limit
         $error("flag_read_seq: MAX_OW must lie in 1..FLAG_W");
      end
      if ((1 << LVL_W) <= MAX_OW) begin : g_bad_lvl
         $error("flag_read_seq: LVL_W too narrow for MAX_OW");
      end
   endgenerate

   rls_state_e        state;
   logic [PAGE_W-1:0] page_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [CW-1:0]     zeros;
   logic              pristine, bad;
   logic [1:0]        bump;
   logic [CNT_W-1:0]  tally [2];

   rls_flag_decode #(.FLAG_W(FLAG_W), .MAX_OW(MAX_OW), .STRICT(STRICT)) u_dec (
      .flags(sense_flags), .zeros(zeros), .pristine(pristine), .bad(bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         page_q   <= '0;
         lvl_q    <= '0;
         data_rdy <= 1'b0;
         rd_err   <= 1'b0;
      end else begin
         data_rdy <= 1'b0;
         rd_err   <= 1'b0;
         unique case (state)
            ST_IDLE: if (rd_req) begin
               page_q <= rd_page;
               lvl_q  <= '0;
               state  <= ST_BASE;
            end
            ST_BASE: if (sense_ack) begin
               if (pristine) begin
                  data_rdy <= 1'b1;
                  state    <= ST_IDLE;
               end else if (bad) begin
                  rd_err <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  lvl_q <= LVL_W'(zeros);
                  state <= ST_RAISED;
               end
            end
            ST_RAISED: if (sense_ack) begin
               data_rdy <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign sense_go   = busy;
   assign sense_lvl  = (state == ST_RAISED) ? lvl_q : '0;
   assign sense_page = page_q;

   assign bump[0] = (state == ST_BASE) && sense_ack && pristine;
   assign bump[1] = (state == ST_RAISED) && sense_ack;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_tally
         rls_tally #(.W(CNT_W), .SAT(1)) u_tally (
            .clk(clk), .rst_n(rst_n), .inc(bump[g]), .count(tally[g])
         );
      end
   endgenerate

   assign n_one = tally[0];
   assign n_two = tally[1];

   a_r2_base_first : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_req) |=> (sense_go && sense_lvl == '0 && sense_page == $past(rd_page)));
   a_r7_hold_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      (sense_go && !sense_ack) |=> (sense_go && $stable(sense_lvl) && $stable(sense_page)));
   a_r4_raised_range : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RAISED) |-> (sense_lvl != '0 && int'(sense_lvl) <= MAX_OW));
   a_r9_page_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_req && !sense_ack) |=> $stable(sense_page));
   a_r10_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(data_rdy && rd_err));
   a_r10_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdy || rd_err) |=> !(data_rdy || rd_err));
   a_r3_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |-> !sense_go);
endmodule

// File: tb/flag_read_seq_test.sv
module flag_read_seq_test;
   localparam int PAGE_W = 16;
   localparam int FLAG_W = 4;
   localparam int LVL_W  = 3;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_req = 1'b0;
   logic [PAGE_W-1:0] rd_page = '0;
   logic              busy, sense_go, data_rdy, rd_err;
   logic [LVL_W-1:0]  sense_lvl;
   logic [PAGE_W-1:0] sense_page;
   logic              sense_ack = 1'b0;
   logic [FLAG_W-1:0] sense_flags = '0;
   logic [CNT_W-1:0]  n_one, n_two;

   int total = 0;
   int bad   = 0;
   int exp_one = 0;
   int exp_two = 0;

   always #4 clk = ~clk;

   flag_read_seq uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_page(rd_page), .busy(busy),
      .sense_go(sense_go), .sense_lvl(sense_lvl), .sense_page(sense_page),
      .sense_ack(sense_ack), .sense_flags(sense_flags), .data_rdy(data_rdy),
      .rd_err(rd_err), .n_one(n_one), .n_two(n_two)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ack_once(input logic [FLAG_W-1:0] f);
      sense_ack = 1'b1; sense_flags = f;
      @(negedge clk);
      sense_ack = 1'b0; sense_flags = '0;
   endtask

   task automatic start(input logic [PAGE_W-1:0] pg);
      @(negedge clk);
      rd_req = 1'b1; rd_page = pg;
      @(negedge clk);
      rd_req = 1'b0; rd_page = '0;
      check("R2 go", int'(sense_go), 1);
      check("R2 level0", int'(sense_lvl), 0);
      check("R2 page", int'(sense_page), int'(pg));
   endtask

   // kind: 0 = one sense, 1 = two senses at level lvl, 2 = error
   task automatic run_read(input logic [PAGE_W-1:0] pg, input logic [FLAG_W-1:0] f,
                           input int kind, input int lvl, input string req);
      start(pg);
      @(negedge clk); @(negedge clk);
      check("R7 held go", int'(sense_go), 1);
      check("R7 held level", int'(sense_lvl), 0);
      check("R7 held page", int'(sense_page), int'(pg));
      ack_once(f);
      if (kind == 0) begin
         check({req, " data_rdy"}, int'(data_rdy), 1);
         check({req, " no second sense"}, int'(sense_go), 0);
         exp_one++;
      end else if (kind == 2) begin
         check({req, " rd_err"}, int'(rd_err), 1);
         check({req, " no data_rdy"}, int'(data_rdy), 0);
         check({req, " no second sense"}, int'(sense_go), 0);
      end else begin
         check({req, " second go"}, int'(sense_go), 1);
         check({req, " raised level"}, int'(sense_lvl), lvl);
         check({req, " same page"}, int'(sense_page), int'(pg));
         check({req, " not ready yet"}, int'(data_rdy), 0);
         @(negedge clk);
         check("R7 raised held", int'(sense_lvl), lvl);
         ack_once(4'b0101);
         check({req, " data_rdy after second"}, int'(data_rdy), 1);
         check({req, " idle after second"}, int'(sense_go), 0);
         exp_two++;
      end
      @(negedge clk);
      check("R10 pulse data_rdy", int'(data_rdy), 0);
      check("R10 pulse rd_err", int'(rd_err), 0);
      check("R8 n_one", int'(n_one), exp_one);
      check("R8 n_two", int'(n_two), exp_two);
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy), 0);
      check("R1 go", int'(sense_go), 0);
      check("R1 data_rdy", int'(data_rdy), 0);
      check("R1 rd_err", int'(rd_err), 0);
      check("R1 n_one", int'(n_one), 0);
      check("R1 n_two", int'(n_two), 0);
   endtask

   task automatic t_busy_ignore();
      start(16'h0A0A);
      rd_req = 1'b1; rd_page = 16'h5555;
      @(negedge clk);
      rd_req = 1'b0; rd_page = '0;
      check("R9 page kept", int'(sense_page), 16'h0A0A);
      check("R9 level kept", int'(sense_lvl), 0);
      ack_once(4'b1111);
      check("R9 read completes", int'(data_rdy), 1);
      exp_one++;
      @(negedge clk);
      check("R9 no extra read", int'(sense_go), 0);
      check("R8 n_one after R9", int'(n_one), exp_one);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_read(16'h0001, 4'b1111, 0, 0, "R3");
      run_read(16'h0102, 4'b1110, 1, 1, "R4 one");
      run_read(16'h0203, 4'b1100, 1, 2, "R4 two");
      run_read(16'h0304, 4'b1000, 1, 3, "R4 three");
      run_read(16'h0405, 4'b0000, 2, 0, "R6 over limit");
      run_read(16'h0506, 4'b1010, 2, 0, "R5 gap");
      run_read(16'h0607, 4'b0111, 2, 0, "R5 reversed");
      t_busy_ignore();
      run_read(16'hFFFF, 4'b1110, 1, 1, "R4 again");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule